// File: doc/BRIEF.md
# Hardware Return Stack with Flagged Pointer

This block is a small hardware stack of fifteen 32-bit rows, addressed by a 6-bit pointer register. The low four bits of the pointer name the top row. The two bits above them are sticky error flags that drive a critical-error line toward an interrupt controller. Each row has a high half and a low half. A push writes both halves at once. The halves can also be moved one at a time over a 16-bit general data bus, and the pointer register itself can be read and written over that same bus.

A single 4-bit operation code selects the action for the cycle. Most operations take one cycle. Moves of the high half take two cycles: a move in bumps the pointer first and then stores the word, and a move out delivers the word first and then drops the pointer. Moves of the low half work on the current top row and leave the pointer where it is. The top row is always visible on a 32-bit output, and a one-hot row select output shows which row the pointer decodes to.

Top module: `hwstk_top`

## Requirements
- R1: Synchronous active-high reset clears the pointer to 0 and every row to zero. After reset, crit_err is low, row_sel is all zero and tos_word is zero.
- R2: Pointer bits 3..0 hold a value p. For p from 1 to 15, row_sel has exactly bit p-1 set and tos_word shows that row. For p = 0, row_sel is zero and tos_word is zero.
- R3: Op code 3 (push) steps the pointer up. In the same cycle it writes {push_hi, push_lo} into the row named by the stepped pointer, so tos_word shows that word on the next cycle.
- R4: Op code 4 (pop) steps the pointer down after the current top has been presented. Op code 1 steps the pointer up and op code 2 steps it down, and neither touches the rows.
- R5: A step is a plain 6-bit add or subtract of one, with the previous bits 5..4 ORed back in. Stepping down from 000000 gives 111111, and stepping up from 001111 gives 010000.
- R6: crit_err is high exactly when pointer bit 4 (stack error) or bit 5 (underflow) is set.
- R7: Bits 5..4 clear only on reset or on op code 9, which loads gdb_in[5:0] into the pointer. In the cycle that op code 10 is presented, gdb_out carries the pointer, zero-extended.
- R8: Op code 5 steps the pointer up in its first cycle and captures gdb_in. In the second cycle it writes the captured value into bits 31..16 of the new top row, and bits 15..0 of that row keep their value.
- R9: In the cycle that op code 6 is presented, gdb_out carries bits 31..16 of the top row and the pointer does not change. The pointer steps down in the following cycle.
- R10: Op code 7 writes gdb_in into bits 15..0 of the current top row. In the cycle that op code 8 is presented, gdb_out carries bits 15..0 of the top row. Neither op code changes the pointer.
- R11: The op code presented during the second cycle of op code 5 or 6 is ignored. Op codes 0 and 11 to 15 do nothing. gdb_out is zero whenever no read (op codes 6, 8, 10) is being served.
- R12: A write aimed at pointer field 0 is dropped. This covers a push that steps from 001111 to 010000 and a low-half write while the field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation for this cycle |
| push_hi | input | 16 | High half of the word written by a push |
| push_lo | input | 16 | Low half of the word written by a push |
| gdb_in | input | 16 | General data bus into the stack |
| gdb_out | output | 16 | General data bus out of the stack |
| tos_word | output | 32 | Current top row, zero when no row is selected |
| sp_value | output | 6 | Pointer register: flags in bits 5..4, field in bits 3..0 |
| row_sel | output | 15 | One-hot decode of the pointer field |
| crit_err | output | 1 | Critical error toward the interrupt controller |

## Verification
The assertions check, on every cycle, that the row select is at most one-hot and is empty with a zero top word when the field is 0. They also check that each error flag stays set until a pointer write, that crit_err follows a raised flag, and that low-half moves, the first cycle of a high-half read and the second cycle of a high-half write leave the pointer unchanged. The bench scenarios are the only place where stored data is compared. They fill and drain the stack across its full depth, wrap the pointer into both error codes, and run the split high-half sequences with a competing op code in their second cycle. They also confirm that writes aimed at field 0 leave every row intact.

// File: rtl/hwstk_pkg.sv
package hwstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_INC   = 4'd1,
        OP_DEC   = 4'd2,
        OP_PUSH  = 4'd3,
        OP_POP   = 4'd4,
        OP_WR_HI = 4'd5,
        OP_RD_HI = 4'd6,
        OP_WR_LO = 4'd7,
        OP_RD_LO = 4'd8,
        OP_WR_SP = 4'd9,
        OP_RD_SP = 4'd10
    } stk_op_e;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_HI_WRITE = 2'd1,
        PH_HI_READ  = 2'd2
    } stk_phase_e;

    // Row write controls for one cycle
    typedef struct packed {
        logic hi_en;   // write bits of the high half
        logic lo_en;   // write bits of the low half
        logic at_next; // address the row named by the stepped-up pointer
        logic from_bus; // data comes from bus/hold instead of push inputs
    } wr_ctl_t;

    function automatic wr_ctl_t wr_ctl(input logic [3:0] op, input stk_phase_e ph);
        wr_ctl_t c;
        c = '0;
        if (ph == PH_HI_WRITE) begin
            c.hi_en    = 1'b1;
            c.from_bus = 1'b1;
        end else if (ph == PH_IDLE) begin
            if (op == OP_PUSH) begin
                c.hi_en   = 1'b1;
                c.lo_en   = 1'b1;
                c.at_next = 1'b1;
            end else if (op == OP_WR_LO) begin
                c.lo_en    = 1'b1;
                c.from_bus = 1'b1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/hwstk_rowdec.sv
module hwstk_rowdec #(
    parameter int PTR_W = 4,
    localparam int ROWS = (1 << PTR_W) - 1
) (
    input  logic [PTR_W-1:0] ptr,
    output logic [ROWS-1:0]  sel
);
    // Field value r+1 selects row r; field 0 selects nothing
    for (genvar r = 0; r < ROWS; r++) begin : g_dec
        assign sel[r] = (ptr == PTR_W'(r + 1));
    end
endmodule

// File: rtl/hwstk_mem.sv
module hwstk_mem #(
    parameter int ROWS   = 15,
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROWS-1:0]   wr_sel,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic [HALF_W-1:0] hi_data,
    input  logic [HALF_W-1:0] lo_data,
    input  logic [ROWS-1:0]   rd_sel,
    output logic [WORD_W-1:0] rd_word
);
    logic [ROWS-1:0][WORD_W-1:0] row_bus;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [WORD_W-1:0] row_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (wr_sel[r]) begin
                if (hi_en) row_q[WORD_W-1:HALF_W] <= hi_data;
                if (lo_en) row_q[HALF_W-1:0]      <= lo_data;
            end
        end
        assign row_bus[r] = row_q;
    end

    always_comb begin
        rd_word = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (rd_sel[r]) rd_word = rd_word | row_bus[r];
        end
    end
endmodule

// File: rtl/hwstk_ptr.sv
module hwstk_ptr
    import hwstk_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int HALF_W = 16,
    localparam int SP_W  = PTR_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic [HALF_W-1:0] gdb_in,
    output logic [SP_W-1:0]   sp_q,
    output logic [PTR_W-1:0]  up_field,
    output stk_phase_e        phase_q,
    output logic [HALF_W-1:0] hold_q
);
    // One step of the pointer: plain add/sub, flags ORed back (sticky)
    function automatic logic [SP_W-1:0] step(input logic [SP_W-1:0] v, input logic up);
        logic [SP_W-1:0] raw;
        raw = up ? (v + 1'b1) : (v - 1'b1);
        return raw | {v[SP_W-1:SP_W-2], {PTR_W{1'b0}}};
    endfunction

    logic [SP_W-1:0]   sp_d, sp_up, sp_dn;
    stk_phase_e        phase_d;
    logic [HALF_W-1:0] hold_d;

    assign sp_up    = step(sp_q, 1'b1);
    assign sp_dn    = step(sp_q, 1'b0);
    assign up_field = sp_up[PTR_W-1:0];

    always_comb begin
        sp_d    = sp_q;
        phase_d = PH_IDLE;
        hold_d  = hold_q;
        case (phase_q)
            PH_HI_WRITE: ;                  // row write happens in storage
            PH_HI_READ:  sp_d = sp_dn;      // delayed post-decrement
            default: begin
                case (op_code)
                    OP_INC, OP_PUSH: sp_d = sp_up;
                    OP_DEC, OP_POP:  sp_d = sp_dn;
                    OP_WR_HI: begin
                        sp_d    = sp_up;
                        hold_d  = gdb_in;
                        phase_d = PH_HI_WRITE;
                    end
                    OP_RD_HI: phase_d = PH_HI_READ;
                    OP_WR_SP: sp_d = gdb_in[SP_W-1:0];
                    default: ;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= '0;
            phase_q <= PH_IDLE;
            hold_q  <= '0;
        end else begin
            sp_q    <= sp_d;
            phase_q <= phase_d;
            hold_q  <= hold_d;
        end
    end
endmodule

// File: rtl/hwstk_top.sv
module hwstk_top
    import hwstk_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int HALF_W = 16,
    localparam int ROWS   = (1 << PTR_W) - 1,
    localparam int SP_W   = PTR_W + 2,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic [HALF_W-1:0] push_hi,
    input  logic [HALF_W-1:0] push_lo,
    input  logic [HALF_W-1:0] gdb_in,
    output logic [HALF_W-1:0] gdb_out,
    output logic [WORD_W-1:0] tos_word,
    output logic [SP_W-1:0]   sp_value,
    output logic [ROWS-1:0]   row_sel,
    output logic              crit_err
);
    stk_phase_e        phase_q;
    logic [PTR_W-1:0]  up_field;
    logic [HALF_W-1:0] hold_q;
    logic [PTR_W-1:0]  wr_field;
    logic [ROWS-1:0]   wr_sel;
    wr_ctl_t           ctl;
    logic [HALF_W-1:0] hi_data, lo_data;
    logic              idle;

    hwstk_ptr #(.PTR_W(PTR_W), .HALF_W(HALF_W)) u_ptr (
        .clk(clk), .rst(rst), .op_code(op_code), .gdb_in(gdb_in),
        .sp_q(sp_value), .up_field(up_field), .phase_q(phase_q), .hold_q(hold_q)
    );

    hwstk_rowdec #(.PTR_W(PTR_W)) u_rd_dec (
        .ptr(sp_value[PTR_W-1:0]), .sel(row_sel)
    );

    assign ctl      = wr_ctl(op_code, phase_q);
    assign wr_field = ctl.at_next ? up_field : sp_value[PTR_W-1:0];

    hwstk_rowdec #(.PTR_W(PTR_W)) u_wr_dec (
        .ptr(wr_field), .sel(wr_sel)
    );

    assign hi_data = ctl.from_bus ? hold_q : push_hi;
    assign lo_data = ctl.from_bus ? gdb_in : push_lo;

    hwstk_mem #(.ROWS(ROWS), .HALF_W(HALF_W)) u_mem (
        .clk(clk), .rst(rst), .wr_sel(wr_sel),
        .hi_en(ctl.hi_en), .lo_en(ctl.lo_en),
        .hi_data(hi_data), .lo_data(lo_data),
        .rd_sel(row_sel), .rd_word(tos_word)
    );

    assign idle     = (phase_q == PH_IDLE);
    assign crit_err = |sp_value[SP_W-1:SP_W-2];

    always_comb begin
        gdb_out = '0;
        if (idle) begin
            case (op_code)
                OP_RD_HI: gdb_out = tos_word[WORD_W-1:HALF_W];
                OP_RD_LO: gdb_out = tos_word[HALF_W-1:0];
                OP_RD_SP: gdb_out = HALF_W'(sp_value);
                default:  gdb_out = '0;
            endcase
        end
    end
endmodule

// File: rtl/hwstk_chk.sv
module hwstk_chk
    import hwstk_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int HALF_W = 16,
    localparam int ROWS   = (1 << PTR_W) - 1,
    localparam int SP_W   = PTR_W + 2,
    localparam int WORD_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_code,
    input stk_phase_e        phase,
    input logic [SP_W-1:0]   sp_q,
    input logic [ROWS-1:0]   row_sel,
    input logic [WORD_W-1:0] tos,
    input logic              crit_err
);
    logic idle_sp_wr;
    assign idle_sp_wr = (phase == PH_IDLE) && (op_code == OP_WR_SP);

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel));

    assert_nosel_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (sp_q[PTR_W-1:0] == '0) |-> (row_sel == '0 && tos == '0));

    assert_crit_follows_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(sp_q[SP_W-2]) || $rose(sp_q[SP_W-1])) |-> crit_err);

    assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (sp_q[SP_W-1] && !idle_sp_wr) |=> sp_q[SP_W-1]);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (sp_q[SP_W-2] && !idle_sp_wr) |=> sp_q[SP_W-2]);

    assert_lo_keeps_sp_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && (op_code == OP_WR_LO || op_code == OP_RD_LO)) |=> $stable(sp_q));

    assert_rdhi_first_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && op_code == OP_RD_HI) |=> $stable(sp_q));

    assert_second_ignores_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI_WRITE) |=> $stable(sp_q));
endmodule

bind hwstk_top hwstk_chk #(.PTR_W(PTR_W), .HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst(rst), .op_code(op_code), .phase(phase_q),
    .sp_q(sp_value), .row_sel(row_sel), .tos(tos_word), .crit_err(crit_err)
);

// File: tb/sim_hwstk_top.sv
module sim_hwstk_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = 4'd0;
    logic [15:0] push_hi = '0, push_lo = '0, gdb_in = '0;
    logic [15:0] gdb_out;
    logic [31:0] tos_word;
    logic [5:0]  sp_value;
    logic [14:0] row_sel;
    logic        crit_err;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model
    logic [5:0]  m_sp;
    logic [31:0] m_mem [1:15];
    logic [15:0] m_hold;

    always #10 clk = ~clk;

    hwstk_top u0 (
        .clk(clk), .rst(rst), .op_code(op_code), .push_hi(push_hi), .push_lo(push_lo),
        .gdb_in(gdb_in), .gdb_out(gdb_out), .tos_word(tos_word), .sp_value(sp_value),
        .row_sel(row_sel), .crit_err(crit_err)
    );

    function automatic logic [5:0] m_step(input logic [5:0] v, input bit up);
        logic [5:0] raw;
        raw = up ? v + 6'd1 : v - 6'd1;
        return raw | (v & 6'h30);
    endfunction

    function automatic logic [31:0] m_top();
        return (m_sp[3:0] == 0) ? 32'd0 : m_mem[m_sp[3:0]];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        logic [14:0] exp_sel;
        exp_sel = (m_sp[3:0] == 0) ? 15'd0 : (15'd1 << (m_sp[3:0] - 1));
        check(tag, "sp_value", 32'(sp_value), 32'(m_sp));
        check(tag, "crit_err", 32'(crit_err), 32'(m_sp[5] | m_sp[4]));
        check(tag, "row_sel",  32'(row_sel),  32'(exp_sel));
        check(tag, "tos_word", tos_word, m_top());
    endtask

    // Called at a falling edge; returns at a falling edge with op NOP
    task automatic run_op(input string tag, input logic [3:0] op, input logic [15:0] hi,
                          input logic [15:0] lo, input logic [15:0] g, input logic [3:0] op2);
        logic [15:0] exp_bus;
        bit two;
        op_code = op; push_hi = hi; push_lo = lo; gdb_in = g;
        #1;
        case (op)
            4'd6:    exp_bus = m_top()[31:16];
            4'd8:    exp_bus = m_top()[15:0];
            4'd10:   exp_bus = {10'd0, m_sp};
            default: exp_bus = 16'd0;
        endcase
        check(tag, "gdb_out", 32'(gdb_out), 32'(exp_bus));
        @(posedge clk);
        two = (op == 4'd5) || (op == 4'd6);
        case (op)
            4'd1: m_sp = m_step(m_sp, 1);
            4'd2, 4'd4: m_sp = m_step(m_sp, 0);
            4'd3: begin
                m_sp = m_step(m_sp, 1);
                if (m_sp[3:0] != 0) m_mem[m_sp[3:0]] = {hi, lo};
            end
            4'd5: begin m_sp = m_step(m_sp, 1); m_hold = g; end
            4'd7: if (m_sp[3:0] != 0) m_mem[m_sp[3:0]][15:0] = g;
            4'd9: m_sp = g[5:0];
            default: ;
        endcase
        if (two) begin
            @(negedge clk);
            op_code = op2; gdb_in = ~g; push_hi = ~hi; push_lo = ~lo;
            #1;
            check(tag, "gdb_out second cycle", 32'(gdb_out), 32'd0);
            @(posedge clk);
            if (op == 4'd5) begin
                if (m_sp[3:0] != 0) m_mem[m_sp[3:0]][31:16] = m_hold;
            end else begin
                m_sp = m_step(m_sp, 0);
            end
        end
        @(negedge clk);
        op_code = 4'd0;
        check_state(tag);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        m_sp = '0; m_hold = '0;
        for (int i = 1; i <= 15; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R1");
        check("R1", "gdb_out idle", 32'(gdb_out), 32'd0);

        // Fill the stack across its full depth
        for (int i = 1; i <= 15; i++)
            run_op("R3", 4'd3, 16'(i * 16'h1111), 16'hA5A5 ^ 16'(i), 16'd0, 4'd0);
        // Push at 001111 -> 010000, write dropped
        run_op("R12", 4'd3, 16'hFFFF, 16'hFFFF, 16'd0, 4'd0);
        run_op("R5", 4'd1, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R7", 4'd2, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R7", 4'd2, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R6", 4'd10, 16'd0, 16'd0, 16'd0, 4'd0);
        // Pointer write clears flags
        run_op("R7", 4'd9, 16'd0, 16'd0, 16'h000F, 4'd0);
        run_op("R7", 4'd10, 16'd0, 16'd0, 16'd0, 4'd0);

        // Half-word moves
        run_op("R10", 4'd8, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R10", 4'd7, 16'd0, 16'd0, 16'h1234, 4'd0);
        run_op("R10", 4'd8, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R9", 4'd6, 16'd0, 16'd0, 16'd0, 4'd3);
        run_op("R9", 4'd6, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R8", 4'd5, 16'd0, 16'd0, 16'hBEEF, 4'd2);
        run_op("R8", 4'd5, 16'd0, 16'd0, 16'hC0DE, 4'd7);
        run_op("R11", 4'd6, 16'd0, 16'd0, 16'd0, 4'd9);

        // Drain to empty and beyond
        for (int i = 0; i < 15; i++) begin
            if (m_sp[3:0] == 0) break;
            run_op("R4", 4'd4, 16'd0, 16'd0, 16'd0, 4'd0);
        end
        run_op("R5", 4'd4, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R6", 4'd1, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R4", 4'd1, 16'd0, 16'd0, 16'd0, 4'd0);
        run_op("R4", 4'd2, 16'd0, 16'd0, 16'd0, 4'd0);

        // Unused codes and NOP do nothing
        run_op("R11", 4'd0, 16'h5555, 16'h5555, 16'h5555, 4'd0);
        for (int c = 11; c <= 15; c++)
            run_op("R11", 4'(c), 16'h5555, 16'h5555, 16'h5555, 4'd0);

        // Low-half write with field 0 is dropped
        run_op("R7", 4'd9, 16'd0, 16'd0, 16'h0000, 4'd0);
        run_op("R12", 4'd7, 16'd0, 16'd0, 16'h7777, 4'd0);
        for (int i = 1; i <= 15; i++)
            run_op("R2", 4'd1, 16'd0, 16'd0, 16'd0, 4'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule